// File: doc/BRIEF.md
# Four-Source Clock Divider with Fast-Path Pre-Divider

This block derives one slow output clock from one of four source clocks. It works inside a single reference-clock domain. Each source is given as a one-cycle enable strobe, and each strobe marks one period of that source. The block counts the strobes of the selected source and produces two outputs. `out_tick` is a one-cycle pulse that marks the start of each output period. `out_lvl` is a level waveform that rises together with each tick.

A 32-bit configuration register sets the division. It has a simple write port and a full readback port, and it holds three fields:
- a source index;
- a pre-divider ratio, used only on the fast source (index 3);
- a post-divider ratio, always used.

Every ratio is stored as the ratio minus one. New settings are staged and applied only when an output period completes. A period that is already running therefore always finishes with the settings it started with.

Top module: `clk_src_prediv_div`

## Requirements
- R1: After reset the register reads 0 and `out_tick` and `out_lvl` are low. Input 0 is then divided by 1: with a strobe every 2 cycles, the ticks are 2 cycles apart.
- R2: `rd_data` returns the last word written, from the cycle after the `wr_en` edge. Register bits 31:18, 15:13, 7:6 and 3:0 have no effect on the output.
- R3: Register bits 17:16 choose which bit of `src_en` is counted.
- R4: With index 3 selected, bits 12:8 hold a pre-divider ratio of field+1 (1 to 32). The output period is then src_period × (pre+1) × (post+1).
- R5: With index 0, 1 or 2 selected, bits 12:8 are ignored and the pre-divider acts as divide-by-1.
- R6: Bits 5:4 hold a post-divider ratio of field+1 (1 to 4), which applies for every source.
- R7: `out_tick` pulses for one cycle, in the cycle after the source strobe that completes an output period. At a total ratio of 1, `out_tick` follows every selected strobe.
- R8: `out_lvl` rises only together with `out_tick`. It stays high for floor(P/2) pre-divided periods, where P is the post ratio, and is low for the rest of the output period. It stays low when P is 1.
- R9: A register write never shortens or stretches the output period in progress. The new source and ratios take effect from the next period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration register |
| wr_data | input | 32 | Word to write |
| rd_data | output | 32 | Current register contents |
| src_en | input | 4 | One-cycle strobes, one per source period, indexed by source |
| out_tick | output | 1 | Pulse marking the start of each output period |
| out_lvl | output | 1 | Divided output level |

## Verification
The hardest case to reach is a write that lands in the middle of a long output period. The old settings must still run to the end of that period, and only then may the new ones take over. To get there, the bench first runs the slowest setting: the fast source with ratios 32 and 4, which gives 128 cycles per period. It waits for one tick, then writes a divide-by-1 setting 40 cycles into the period. It then checks that the next tick still arrives 128 cycles after the previous one, and that the tick after that comes one cycle later. The sources strobe at periods 1, 2, 3 and 5 cycles, so each output period is a distinct product that shows whether the pre-divider was applied or bypassed.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W    = 32;
  localparam int NUM_SRC  = 4;
  localparam int SEL_W    = $clog2(NUM_SRC);
  localparam int PRE_W    = 5;
  localparam int POST_W   = 2;
  localparam int FAST_SRC = 3;
  localparam int SEL_LSB  = 16;
  localparam int PRE_LSB  = 8;
  localparam int POST_LSB = 4;

  typedef struct packed {
    logic [SEL_W-1:0]  sel;
    logic [PRE_W-1:0]  pre;
    logic [POST_W-1:0] post;
  } cfg_t;
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_q = sync_q[STAGES-1];
endmodule

// File: rtl/clkdiv_cfg_reg.sv
module clkdiv_cfg_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] q
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     word_q <= '0;
    else if (wr_en) word_q <= wr_data;
  end

  assign q = word_q;
endmodule

// File: rtl/clkdiv_pre.sv
module clkdiv_pre #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         wrap
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  assign wrap = step && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (step) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/clkdiv_post.sv
module clkdiv_post #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic [W-1:0] lim,
  input  logic [W-1:0] lim_nxt,
  output logic         wrap,
  output logic         tick,
  output logic         lvl
);
  localparam int HW = W + 1;

  logic [W-1:0]  cnt_q, cnt_d;
  logic [W-1:0]  lim_d;
  logic [HW-1:0] half;
  logic          lvl_q, lvl_d;
  logic          tick_q;

  assign wrap = step && (cnt_q == lim);

  always_comb begin
    cnt_d = cnt_q;
    if (step) cnt_d = wrap ? '0 : cnt_q + 1'b1;
    lim_d = wrap ? lim_nxt : lim;
    half  = ({1'b0, lim_d} + HW'(1)) >> 1;
    lvl_d = {1'b0, cnt_d} < half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lvl_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      if (step) cnt_q <= cnt_d;
      lvl_q  <= lvl_d;
      tick_q <= wrap;
    end
  end

  assign tick = tick_q;
  assign lvl  = lvl_q;
endmodule

// File: rtl/clk_src_prediv_div.sv
module clk_src_prediv_div
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic [NUM_SRC-1:0] src_en,
  output logic             out_tick,
  output logic             out_lvl
);
  logic             rst_q;
  logic [REG_W-1:0] cfg_q;
  cfg_t             cfg_new;
  cfg_t             act_cfg, act_d;
  logic             sel_en;
  logic [PRE_W-1:0] pre_lim;
  logic             pre_wrap;
  logic             post_wrap;

  clkdiv_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q(rst_q)
  );

  clkdiv_cfg_reg #(.W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_data(wr_data), .q(cfg_q)
  );

  assign rd_data = cfg_q;

  always_comb begin
    cfg_new.sel  = cfg_q[SEL_LSB  +: SEL_W];
    cfg_new.pre  = cfg_q[PRE_LSB  +: PRE_W];
    cfg_new.post = cfg_q[POST_LSB +: POST_W];
  end

  // staged settings load only when an output period completes
  always_comb act_d = post_wrap ? cfg_new : act_cfg;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) act_cfg <= '0;
    else        act_cfg <= act_d;
  end

  always_comb begin
    sel_en  = src_en[act_cfg.sel];
    pre_lim = (act_cfg.sel == SEL_W'(FAST_SRC)) ? act_cfg.pre : '0;
  end

  clkdiv_pre #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_q), .step(sel_en), .lim(pre_lim), .wrap(pre_wrap)
  );

  clkdiv_post #(.W(POST_W)) u_post (
    .clk(clk), .rst_n(rst_q), .step(pre_wrap), .lim(act_cfg.post),
    .lim_nxt(cfg_new.post), .wrap(post_wrap), .tick(out_tick), .lvl(out_lvl)
  );
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker
  import clkdiv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [REG_W-1:0]   wr_data,
  input logic [REG_W-1:0]   rd_data,
  input logic [NUM_SRC-1:0] src_en,
  input logic               out_tick,
  input logic               out_lvl,
  input cfg_t               act
);
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(rst_n)) |-> (rd_data == $past(wr_data)));

  a_r7_tick_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    out_tick |-> $past(|src_en));

  a_r8_lvl_rises_with_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_lvl) |-> out_tick);

  a_r9_switch_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act) |-> out_tick);
endmodule

bind clk_src_prediv_div clkdiv_checker i_chk (
  .clk(clk), .rst_n(rst_q), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .src_en(src_en), .out_tick(out_tick),
  .out_lvl(out_lvl), .act(act_cfg)
);

// File: tb/test_clk_src_prediv_div.sv
module test_clk_src_prediv_div;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic [3:0]  src_en;
  logic        out_tick;
  logic        out_lvl;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  clk_src_prediv_div i_clk_src_prediv_div (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .src_en(src_en), .out_tick(out_tick), .out_lvl(out_lvl)
  );

  // source strobe periods in reference cycles
  localparam int PER [4] = '{2, 3, 5, 1};
  logic [2:0] scnt [4];

  always @(posedge clk or negedge rst_n) begin
    for (int i = 0; i < 4; i++) begin
      if (!rst_n) scnt[i] <= '0;
      else        scnt[i] <= (scnt[i] == 3'(PER[i] - 1)) ? 3'd0 : scnt[i] + 3'd1;
    end
  end

  always_comb begin
    for (int i = 0; i < 4; i++) src_en[i] = (scnt[i] == 3'd0);
  end

  typedef struct packed {
    logic [1:0]  sel;
    logic [4:0]  pre;
    logic [1:0]  post;
    logic [15:0] iv;
    logic [15:0] hi;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 5'd0,  2'd0, 16'd2,   16'd0},
    '{2'd0, 5'd7,  2'd1, 16'd4,   16'd2},
    '{2'd1, 5'd0,  2'd2, 16'd9,   16'd3},
    '{2'd2, 5'd31, 2'd3, 16'd20,  16'd10},
    '{2'd3, 5'd0,  2'd0, 16'd1,   16'd0},
    '{2'd3, 5'd4,  2'd0, 16'd5,   16'd0},
    '{2'd3, 5'd31, 2'd3, 16'd128, 16'd64},
    '{2'd3, 5'd2,  2'd2, 16'd9,   16'd3},
    '{2'd3, 5'd31, 2'd0, 16'd32,  16'd0},
    '{2'd1, 5'd5,  2'd3, 16'd12,  16'd6}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  function automatic logic [31:0] pack(input logic [1:0] s, input logic [4:0] p,
                                       input logic [1:0] q);
    return {14'd0, s, 3'd0, p, 2'd0, q, 4'd0};
  endfunction

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_tick();
    int k;
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!out_tick && k < 2000);
    if (!out_tick) check("tick timeout", 0, 1);
  endtask

  task automatic measure(output int iv, output int hi);
    wait_tick();
    hi = int'(out_lvl);
    iv = 0;
    forever begin
      @(negedge clk);
      iv++;
      if (out_tick || iv >= 2000) break;
      hi += int'(out_lvl);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check("watchdog", 1, 0);
    summary();
    $finish;
  end

  initial begin
    int iv, hi, cnt;
    rst_n   = 1'b0;
    wr_en   = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 rd_data at reset", int'(rd_data), 0);
    check("R1 out_tick at reset", int'(out_tick), 0);
    check("R1 out_lvl at reset", int'(out_lvl), 0);
    rst_n = 1'b1;
    measure(iv, hi);
    check("R1 default interval", iv, 2);
    check("R1 default high", hi, 0);

    // table walk: R3 R4 R5 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      wr(pack(VEC[v].sel, VEC[v].pre, VEC[v].post));
      wait_tick();
      wait_tick();
      measure(iv, hi);
      check("R3 R4 R5 R6 R7 interval", iv, int'(VEC[v].iv));
      check("R8 high time", hi, int'(VEC[v].hi));
    end

    // R2 readback of all bits, and bits outside the fields have no effect
    wr(32'hFFFD_E0DF);
    check("R2 readback junk bits", int'(rd_data), int'(32'hFFFD_E0DF));
    wait_tick();
    wait_tick();
    measure(iv, hi);
    check("R2 junk bits interval", iv, 6);
    check("R2 junk bits high", hi, 3);
    wr(32'hA5A5_5A5A);
    check("R2 readback pattern", int'(rd_data), int'(32'hA5A5_5A5A));

    // R9 mid-period write keeps the running period intact
    wr(pack(2'd3, 5'd31, 2'd3));
    wait_tick();
    wait_tick();
    wait_tick();
    cnt = 0;
    repeat (40) @(negedge clk);
    cnt += 40;
    wr(pack(2'd3, 5'd0, 2'd0));
    cnt += 2;
    while (!out_tick && cnt < 2000) begin
      @(negedge clk);
      cnt++;
    end
    check("R9 period in progress", cnt, 128);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (!out_tick && cnt < 2000);
    check("R9 R7 next period ratio 1", cnt, 1);
    @(negedge clk);
    check("R7 tick on every strobe", int'(out_tick), 1);

    summary();
    $finish;
  end
endmodule